// File: doc/BRIEF.md
# Serial Test Access Controller

This block is the test port of a chip. A slow serial link of four wires (test clock, mode select, serial data in, serial data out) and an optional synchronous reset steer a sixteen-state sequencer. That sequencer routes either an instruction register or one of two data registers between the serial input and the serial output. Pulling the mode select high for five clocks always returns the port to its reset state.

Three operations are decoded. The first is a one-bit pass-through that shortens the serial path. The second is a pin-drive mode in which a chain of boundary cells takes over the chip's external pins. The third is a snapshot-and-preload mode. It records the current pin levels and lets new override values be staged without driving them. The boundary chain has a shift stage and a separate output latch. The latch is written only at the end of a data scan, so the override outputs do not move while bits stream through.

Top module: `scan_access_ctrl`

## Requirements
- R1: The sequencer has 16 states and advances only on the rising test clock, steered by the mode select. Five consecutive rising edges with mode select high reach the reset state from any state.
- R2: The reset input is active high and sampled on the rising test clock. It forces the reset state, loads the pass-through code, clears the override latch and leaves the serial output disabled.
- R3: While the sequencer is in its reset state, the instruction becomes all zeros (pass-through).
- R4: The instruction is IR_W bits wide (2 by default), shifted in least significant bit first. On capture the instruction shifter loads the pattern ...01, so bit 0 (value 1) leaves first. A newly shifted code takes effect only when the sequencer passes its instruction-update state.
- R5: Code all zeros selects a single-bit data path that captures 0 and then delays the serial input by one clock.
- R6: Code all ones selects pin-drive mode. The boundary chain is the data path, `pin_drive` is high, and `pin_out` shows the override latch.
- R7: Any other code (01, 10) selects snapshot mode. The boundary chain is the data path and the latch can be preloaded, but `pin_drive` stays low.
- R8: The serial output changes on the falling test clock. Its enable is high only while the sequencer sits in one of the two shift states.
- R9: The override latch changes only in the data-update state. `pin_out` holds steady during capture and shift.
- R10: On data capture, boundary bit i takes `pin_in[i]`. Shifting moves bits toward bit 0, so bit 0 leaves first and the serial input enters at bit BSR_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst | input | 1 | Synchronous active-high reset of the port |
| tms | input | 1 | Mode select steering the sequencer |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling clock |
| tdo_oe | output | 1 | Serial output enable, high in shift states |
| pin_in | input | BSR_W | Present pin levels sampled by the boundary chain |
| pin_out | output | BSR_W | Override values held in the boundary latch |
| pin_drive | output | 1 | High when pin-drive mode is the current instruction |

## Verification
A wrong sequencer state shows up as a shifted or truncated serial stream. The bench sees it in the first scan that follows: the instruction capture pattern, the bypass delay or the pin snapshot comes out at the wrong bit position. A wrong instruction shows as the wrong scan length or a wrong `pin_drive` level right after the update state. A latch that moves early shows up as a `pin_out` change in the middle of a shift, and the bench samples `pin_out` on every scan clock.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic [3:0] {
    ST_RESET   = 4'd0,
    ST_IDLE    = 4'd1,
    ST_SEL_DR  = 4'd2,
    ST_CAP_DR  = 4'd3,
    ST_SH_DR   = 4'd4,
    ST_EX1_DR  = 4'd5,
    ST_PAU_DR  = 4'd6,
    ST_EX2_DR  = 4'd7,
    ST_UPD_DR  = 4'd8,
    ST_SEL_IR  = 4'd9,
    ST_CAP_IR  = 4'd10,
    ST_SH_IR   = 4'd11,
    ST_EX1_IR  = 4'd12,
    ST_PAU_IR  = 4'd13,
    ST_EX2_IR  = 4'd14,
    ST_UPD_IR  = 4'd15
  } tap_state_e;

  typedef enum logic [1:0] {
    OP_BYPASS = 2'd0,
    OP_SAMPLE = 2'd1,
    OP_EXTEST = 2'd2
  } op_e;
endpackage

// File: rtl/scan_fsm.sv
module scan_fsm
  import scan_pkg::*;
(
  input  logic tck,
  input  logic trst,
  input  logic tms,
  output logic in_reset,
  output logic cap_ir,
  output logic sh_ir,
  output logic upd_ir,
  output logic cap_dr,
  output logic sh_dr,
  output logic upd_dr
);
  tap_state_e state, nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_RESET:  nxt = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   nxt = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: nxt = tms ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_IDLE;
      default:   nxt = ST_RESET;
    endcase
  end

  always_ff @(posedge tck) begin
    if (trst) state <= ST_RESET;
    else      state <= nxt;
  end

  assign in_reset = (state == ST_RESET);
  assign cap_ir   = (state == ST_CAP_IR);
  assign sh_ir    = (state == ST_SH_IR);
  assign upd_ir   = (state == ST_UPD_IR);
  assign cap_dr   = (state == ST_CAP_DR);
  assign sh_dr    = (state == ST_SH_DR);
  assign upd_dr   = (state == ST_UPD_DR);

  // R1: five high mode-select clocks always land in the reset state
  a_r1_five_ones: assert property (@(posedge tck) disable iff (trst)
    (tms && $past(tms, 1) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4))
      |=> (state == ST_RESET));

  // R2: reset input is synchronous
  a_r2_sync_reset: assert property (@(posedge tck)
    trst |=> (state == ST_RESET));

  // R1: at most one control strobe at a time
  a_r1_one_strobe: assert property (@(posedge tck) disable iff (trst)
    $onehot0({cap_ir, sh_ir, upd_ir, cap_dr, sh_dr, upd_dr}));
endmodule

// File: rtl/scan_ir.sv
module scan_ir
  import scan_pkg::*;
#(
  parameter int IR_W = 2
) (
  input  logic tck,
  input  logic trst,
  input  logic tdi,
  input  logic in_reset,
  input  logic cap,
  input  logic sh,
  input  logic upd,
  output op_e  op,
  output logic sr_lsb
);
  localparam logic [IR_W-1:0] CODE_BYP = '0;
  localparam logic [IR_W-1:0] CODE_EXT = '1;
  localparam logic [IR_W-1:0] CAP_PAT  = IR_W'(1);

  logic [IR_W-1:0] sr;
  logic [IR_W-1:0] instr;

  always_ff @(posedge tck) begin
    if (trst) begin
      sr <= '0;
    end else if (cap) begin
      sr <= CAP_PAT;
    end else if (sh) begin
      if (IR_W == 1) sr <= tdi;
      else           sr <= {tdi, sr[IR_W-1:1]};
    end
  end

  always_ff @(posedge tck) begin
    if (trst || in_reset) instr <= CODE_BYP;
    else if (upd)         instr <= sr;
  end

  always_comb begin
    if (instr == CODE_BYP)      op = OP_BYPASS;
    else if (instr == CODE_EXT) op = OP_EXTEST;
    else                        op = OP_SAMPLE;
  end

  assign sr_lsb = sr[0];

  // R3: the reset state loads the pass-through code
  a_r3_reset_bypass: assert property (@(posedge tck) disable iff (trst)
    in_reset |=> (instr == CODE_BYP));

  // R4: instruction only changes through the update state or reset state
  a_r4_instr_hold: assert property (@(posedge tck) disable iff (trst)
    (!upd && !in_reset) |=> $stable(instr));
endmodule

// File: rtl/scan_bsr.sv
module scan_bsr #(
  parameter int BSR_W = 8
) (
  input  logic             tck,
  input  logic             trst,
  input  logic             tdi,
  input  logic             sel,
  input  logic             cap,
  input  logic             sh,
  input  logic             upd,
  input  logic [BSR_W-1:0] pin_in,
  output logic [BSR_W-1:0] latch,
  output logic             sr_lsb
);
  logic [BSR_W-1:0] sr;

  generate
    for (genvar i = 0; i < BSR_W; i++) begin : g_cell
      logic shift_src;
      if (i == BSR_W - 1) begin : g_top
        assign shift_src = tdi;
      end else begin : g_mid
        assign shift_src = sr[i+1];
      end

      always_ff @(posedge tck) begin
        if (trst)            sr[i] <= 1'b0;
        else if (sel && cap) sr[i] <= pin_in[i];
        else if (sel && sh)  sr[i] <= shift_src;
      end

      always_ff @(posedge tck) begin
        if (trst)            latch[i] <= 1'b0;
        else if (sel && upd) latch[i] <= sr[i];
      end
    end
  endgenerate

  assign sr_lsb = sr[0];

  // R9: override latch holds outside the data-update state
  a_r9_latch_hold: assert property (@(posedge tck) disable iff (trst)
    !(sel && upd) |=> $stable(latch));
endmodule

// File: rtl/scan_access_ctrl.sv
module scan_access_ctrl
  import scan_pkg::*;
#(
  parameter int IR_W  = 2,
  parameter int BSR_W = 8
) (
  input  logic             tck,
  input  logic             trst,
  input  logic             tms,
  input  logic             tdi,
  output logic             tdo,
  output logic             tdo_oe,
  input  logic [BSR_W-1:0] pin_in,
  output logic [BSR_W-1:0] pin_out,
  output logic             pin_drive
);
  logic in_reset, cap_ir, sh_ir, upd_ir, cap_dr, sh_dr, upd_dr;
  op_e  op;
  logic ir_lsb, bsr_lsb, byp_q, bsr_sel, dr_bit;

  scan_fsm u_fsm (
    .tck(tck), .trst(trst), .tms(tms), .in_reset(in_reset),
    .cap_ir(cap_ir), .sh_ir(sh_ir), .upd_ir(upd_ir),
    .cap_dr(cap_dr), .sh_dr(sh_dr), .upd_dr(upd_dr)
  );

  scan_ir #(.IR_W(IR_W)) u_ir (
    .tck(tck), .trst(trst), .tdi(tdi), .in_reset(in_reset),
    .cap(cap_ir), .sh(sh_ir), .upd(upd_ir), .op(op), .sr_lsb(ir_lsb)
  );

  assign bsr_sel = (op != OP_BYPASS);

  scan_bsr #(.BSR_W(BSR_W)) u_bsr (
    .tck(tck), .trst(trst), .tdi(tdi), .sel(bsr_sel),
    .cap(cap_dr), .sh(sh_dr), .upd(upd_dr),
    .pin_in(pin_in), .latch(pin_out), .sr_lsb(bsr_lsb)
  );

  always_ff @(posedge tck) begin
    if (trst)                          byp_q <= 1'b0;
    else if (!bsr_sel && cap_dr)       byp_q <= 1'b0;
    else if (!bsr_sel && sh_dr)        byp_q <= tdi;
  end

  assign dr_bit    = bsr_sel ? bsr_lsb : byp_q;
  assign pin_drive = (op == OP_EXTEST);

  always_ff @(negedge tck) begin
    if (trst) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= sh_ir | sh_dr;
      if (sh_ir)      tdo <= ir_lsb;
      else if (sh_dr) tdo <= dr_bit;
      else            tdo <= 1'b0;
    end
  end

  // R8: at each rising edge the enable set on the prior falling edge matches the shift states
  a_r8_oe_shift: assert property (@(posedge tck) disable iff (trst)
    tdo_oe == (sh_ir | sh_dr));

  // R6: pins are never driven directly after the reset state
  a_r6_no_drive_after_reset: assert property (@(posedge tck) disable iff (trst)
    in_reset |=> !pin_drive);
endmodule

// File: tb/test_scan_access_ctrl.sv
`timescale 1ns/100ps
module test_scan_access_ctrl;
  localparam int IR_W  = 2;
  localparam int BSR_W = 8;

  logic tck = 1'b0;
  logic trst = 1'b1, tms = 1'b1, tdi = 1'b0;
  logic tdo, tdo_oe, pin_drive;
  logic [BSR_W-1:0] pin_in = '0;
  logic [BSR_W-1:0] pin_out;

  int n_chk = 0, n_fail = 0;
  int seed_dummy;

  always #2.5 tck = ~tck;

  scan_access_ctrl #(.IR_W(IR_W), .BSR_W(BSR_W)) i_scan_access_ctrl (
    .tck(tck), .trst(trst), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .pin_in(pin_in), .pin_out(pin_out), .pin_drive(pin_drive)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // sample outputs after the falling edge, then set inputs for the next rising edge
  task automatic step(input bit m, input bit d, output bit o, output bit oe);
    @(negedge tck); #1;
    o = tdo; oe = tdo_oe;
    tms = m; tdi = d;
  endtask

  task automatic idle(input int n);
    bit o, oe;
    for (int i = 0; i < n; i++) step(0, 0, o, oe);
  endtask

  task automatic scan_ir(input logic [IR_W-1:0] code, output logic [IR_W-1:0] cap);
    bit o, oe;
    step(1, 0, o, oe); step(1, 0, o, oe); step(0, 0, o, oe); step(0, 0, o, oe);
    for (int i = 0; i < IR_W; i++) begin
      step(i == IR_W - 1, code[i], o, oe);
      cap[i] = o;
      chk(oe == 1'b1, "R8 oe in shift-ir", oe, 1);
    end
    step(1, 0, o, oe);
    step(0, 0, o, oe);
    step(0, 0, o, oe);
  endtask

  task automatic scan_dr(input int n, input logic [31:0] din, output logic [31:0] dout);
    bit o, oe;
    logic [BSR_W-1:0] hold;
    dout = '0;
    step(1, 0, o, oe); step(0, 0, o, oe); step(0, 0, o, oe);
    hold = pin_out;
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i], o, oe);
      dout[i] = o;
      chk(oe == 1'b1, "R8 oe in shift-dr", oe, 1);
      chk(pin_out == hold, "R9 latch stable while shifting", pin_out, hold);
    end
    step(1, 0, o, oe);
    step(0, 0, o, oe);
    step(0, 0, o, oe);
  endtask

  function automatic logic [31:0] bypass_exp(input int n, input logic [31:0] d);
    return {d[30:0], 1'b0} & ((32'd1 << n) - 1);
  endfunction

  initial begin : watchdog
    #(5.0 * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [IR_W-1:0] irc;
    logic [31:0] dout, din;
    logic [BSR_W-1:0] pat, pins;
    bit o, oe;
    seed_dummy = $urandom(32'h5eed_1234);

    repeat (3) @(negedge tck);
    #1; trst = 1'b0; tms = 1'b0;
    step(0, 0, o, oe);
    // R2: reset state
    chk(tdo_oe == 0, "R2 oe after reset", tdo_oe, 0);
    chk(pin_out == 0, "R2 latch cleared", pin_out, 0);
    chk(pin_drive == 0, "R2 no drive", pin_drive, 0);
    chk(tdo_oe == 0, "R8 oe low in idle", tdo_oe, 0);

    // R4: capture pattern, R5: bypass by default (R3)
    scan_ir(2'b00, irc);
    chk(irc == 2'b01, "R4 capture pattern", irc, 2'b01);
    din = 32'h0000_00B5;
    scan_dr(8, din, dout);
    chk(dout == bypass_exp(8, din), "R5 bypass one-clock delay", dout, bypass_exp(8, din));

    // R7 + R10: snapshot mode captures pins, preload without driving
    pins = 8'hA6; pin_in = pins;
    scan_ir(2'b01, irc);
    chk(pin_drive == 0, "R7 sample no drive", pin_drive, 0);
    pat = 8'h3C;
    scan_dr(BSR_W, {24'h0, pat}, dout);
    chk(dout[BSR_W-1:0] == pins, "R10 capture pins", dout[BSR_W-1:0], pins);
    chk(pin_out == pat, "R7 preload latch", pin_out, pat);
    chk(pin_drive == 0, "R7 preload not driven", pin_drive, 0);

    // R6: pin-drive mode; R4 code takes effect only after update
    scan_ir(2'b11, irc);
    chk(irc == 2'b01, "R4 capture pattern again", irc, 2'b01);
    chk(pin_drive == 1, "R6 drive on", pin_drive, 1);
    for (int k = 0; k < 6; k++) begin
      pins = BSR_W'($urandom); pin_in = pins;
      pat  = BSR_W'($urandom);
      scan_dr(BSR_W, {24'h0, pat}, dout);
      chk(dout[BSR_W-1:0] == pins, "R10 extest capture", dout[BSR_W-1:0], pins);
      chk(pin_out == pat, "R6 override latch", pin_out, pat);
      chk(pin_drive == 1, "R6 drive held", pin_drive, 1);
    end

    // R7: code 10 is also snapshot mode
    scan_ir(2'b10, irc);
    chk(pin_drive == 0, "R7 code 10 no drive", pin_drive, 0);
    pins = 8'h5A; pin_in = pins;
    scan_dr(BSR_W, 32'h0, dout);
    chk(dout[BSR_W-1:0] == pins, "R7 code 10 captures", dout[BSR_W-1:0], pins);

    // R1 + R3: random walk then five ones reaches reset, pass-through restored
    for (int k = 0; k < 4; k++) begin
      scan_ir(2'b11, irc);
      for (int j = 0; j < 23; j++) step(bit'($urandom), bit'($urandom), o, oe);
      for (int j = 0; j < 5; j++) step(1, 0, o, oe);
      step(0, 0, o, oe);
      step(0, 0, o, oe);
      chk(pin_drive == 0, "R1 five ones then R3 bypass", pin_drive, 0);
      din = $urandom & 32'h3FF;
      scan_dr(10, din, dout);
      chk(dout == bypass_exp(10, din), "R3 bypass after reset state", dout, bypass_exp(10, din));
    end

    // R2: reset mid-scan in pin-drive mode
    scan_ir(2'b11, irc);
    scan_dr(BSR_W, 32'hFF, dout);
    chk(pin_out == 8'hFF, "R6 latch set", pin_out, 8'hFF);
    step(1, 0, o, oe); step(0, 0, o, oe); step(0, 0, o, oe); step(0, 1, o, oe);
    @(negedge tck); #1; trst = 1'b1;
    @(negedge tck); #1; trst = 1'b0; tms = 1'b0;
    step(0, 0, o, oe);
    chk(pin_out == 0, "R2 latch cleared mid-scan", pin_out, 0);
    chk(pin_drive == 0, "R2 drive off", pin_drive, 0);
    chk(tdo_oe == 0, "R2 oe off", tdo_oe, 0);
    idle(2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule